// File: doc/BRIEF.md
# Register-List Stack and Block Transfer Sequencer

This block turns one register-list request into a series of single-word memory accesses. It handles four stack operations and two block transfers. A push walks the list from the highest register down and decrements the pointer before each store. A pop walks the list from the lowest register up and increments the pointer after each load. A block load or block store walks upward from a word-aligned base.

Two variants add an extra slot:
- Push-with-link stores the link value before anything else, at the highest address.
- Pop-with-PC loads a program-counter word after every listed register, clears its bit 0 and presents it on a load strobe.

The block has one memory port. It issues at most one access per cycle, and read data returns one cycle after the read is issued. The caller holds the eight low register values and the link value stable while the block is busy. Loaded words come back as write-back strobes that carry a register index. The block reports the final pointer together with `done`.

Top module: `stk_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, `busy`, `done`, `mem_req`, `wb_en`, `sp_we` and `pc_load` are all low.
- R2: Op code 0 (push) stores each listed register, highest index first. Before each store the pointer drops by 4, and the store goes to the new pointer. `sp_val` ends at base minus 4 times the number of listed registers.
- R3: Op code 1 (push with link) stores `lr_val` first, at base minus 4, before any listed register. The pointer ends one extra word lower than for op code 0.
- R4: Op code 2 (pop) reads from the pointer and then raises it by 4 for each listed register, lowest index first. Each word read appears on `wb_en`/`wb_idx`/`wb_data` exactly one cycle after its read is issued.
- R5: Op code 3 (pop with PC) reads one more word after all listed registers, and raises the pointer by 4 once more. `pc_load` pulses in the `done` cycle, and `pc_val` is that word with bit 0 cleared.
- R6: Op codes 4 (block load) and 5 (block store) use the base with its low two bits cleared. They move the listed registers lowest index first at ascending addresses, 4 apart. `sp_val` returns the aligned base plus 4 times the register count.
- R7: Accesses go out on back-to-back cycles starting in the first cycle after acceptance. `done` (together with `sp_we`) is high for exactly one cycle, the cycle right after the last access.
- R8: An empty list with op code 0, 2, 4 or 5 issues no access. It raises `done` in the first cycle after acceptance with `sp_val` equal to the request base, unaligned included.
- R9: A request made while `busy` is high is ignored, and so are op codes 6 and 7. No access or `busy` follows from them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_op | input | 3 | Operation code 0..5 |
| req_list | input | NREG | Register list, bit i selects register i |
| req_base | input | DW | Stack pointer or block base |
| lo_regs | input | NREG*DW | Low register values, register i at bits i*DW upward |
| lr_val | input | DW | Link register value |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | DW | Access address |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, one cycle after the read |
| wb_en | output | 1 | Register write-back strobe |
| wb_idx | output | IW | Write-back register index |
| wb_data | output | DW | Write-back value |
| sp_we | output | 1 | Final pointer valid |
| sp_val | output | DW | Final pointer or base |
| pc_load | output | 1 | Program counter load strobe |
| pc_val | output | DW | Loaded PC with bit 0 cleared |
| done | output | 1 | Operation complete |
| busy | output | 1 | Operation in progress |

## Verification
The hardest situation to reach from the ports is a second request arriving in the middle of a long sequence. That request must leave the running sequence untouched and must not start afterwards. The bench pulses a conflicting full-list pop while a transfer is under way. It then checks that the access trace is unchanged and that the port stays quiet after `done`. Unaligned bases with empty lists, and the link and PC slots with full or empty lists, are driven as directed cases. Random ops, lists and bases then cover the rest against a reference model of the access trace.

// File: rtl/stk_seq_pkg.sv
package stk_seq_pkg;
   typedef enum logic [2:0] {
      OP_PUSH    = 3'd0,
      OP_PUSH_LR = 3'd1,
      OP_POP     = 3'd2,
      OP_POP_PC  = 3'd3,
      OP_BLK_LD  = 3'd4,
      OP_BLK_ST  = 3'd5
   } stk_op_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_FIN  = 2'd2
   } stk_state_e;
endpackage

// File: rtl/stk_pick.sv
module stk_pick #(
   parameter int N          = 8,
   parameter int IW         = 3,
   parameter bit HIGH_FIRST = 1'b0
) (
   input  logic [N-1:0]  vec,
   output logic [IW-1:0] idx,
   output logic          any
);
   initial begin
      if (IW != $clog2(N)) $error("stk_pick: IW must equal clog2(N)");
   end

   generate
      if (HIGH_FIRST) begin : g_high
         always_comb begin
            idx = '0;
            for (int i = 0; i < N; i++)
               if (vec[i]) idx = IW'(i);
         end
      end else begin : g_low
         always_comb begin
            idx = '0;
            for (int i = N - 1; i >= 0; i--)
               if (vec[i]) idx = IW'(i);
         end
      end
   endgenerate

   assign any = |vec;
endmodule

// File: rtl/stk_rdpipe.sv
module stk_rdpipe #(
   parameter int DW = 32,
   parameter int IW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          issue,
   input  logic [IW-1:0] issue_idx,
   input  logic          issue_pc,
   input  logic [DW-1:0] rdata,
   output logic          wb_en,
   output logic [IW-1:0] wb_idx,
   output logic [DW-1:0] wb_data,
   output logic          pc_load,
   output logic [DW-1:0] pc_val
);
   logic          pend_v;
   logic          pend_pc;
   logic [IW-1:0] pend_idx;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_v   <= 1'b0;
         pend_pc  <= 1'b0;
         pend_idx <= '0;
      end else begin
         pend_v   <= issue;
         pend_pc  <= issue & issue_pc;
         pend_idx <= issue_idx;
      end
   end

   assign wb_en   = pend_v & ~pend_pc;
   assign wb_idx  = pend_idx;
   assign wb_data = rdata;
   assign pc_load = pend_v & pend_pc;
   assign pc_val  = {rdata[DW-1:1], 1'b0};
endmodule

// File: rtl/stk_seq.sv
module stk_seq
   import stk_seq_pkg::*;
#(
   parameter int DW   = 32,
   parameter int NREG = 8,
   parameter int IW   = $clog2(NREG)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [2:0]        req_op,
   input  logic [NREG-1:0]   req_list,
   input  logic [DW-1:0]     req_base,
   input  logic [NREG*DW-1:0] lo_regs,
   input  logic [DW-1:0]     lr_val,
   output logic              mem_req,
   output logic              mem_we,
   output logic [DW-1:0]     mem_addr,
   output logic [DW-1:0]     mem_wdata,
   input  logic [DW-1:0]     mem_rdata,
   output logic              wb_en,
   output logic [IW-1:0]     wb_idx,
   output logic [DW-1:0]     wb_data,
   output logic              sp_we,
   output logic [DW-1:0]     sp_val,
   output logic              pc_load,
   output logic [DW-1:0]     pc_val,
   output logic              done,
   output logic              busy
);
   localparam int STEP = DW / 8;
   localparam int ALW  = $clog2(STEP);
   localparam logic [DW-1:0] ALIGN_MASK = ~DW'(STEP - 1);

   initial begin
      if (DW % 8 != 0 || DW < 16) $error("stk_seq: DW must be a byte multiple of at least 16");
      if (IW != $clog2(NREG))     $error("stk_seq: IW must equal clog2(NREG)");
      if (ALW < 1)                $error("stk_seq: word must span several bytes");
   end

   stk_state_e      st_q;
   stk_op_e         op_q;
   logic [NREG-1:0] rem_q;
   logic            lr_pend_q;
   logic            pc_pend_q;
   logic [DW-1:0]   ptr_q;

   // candidate slots
   logic [IW-1:0] hi_idx, lo_idx;
   logic          hi_any, lo_any;

   stk_pick #(.N(NREG), .IW(IW), .HIGH_FIRST(1'b1)) u_pick_hi (
      .vec(rem_q), .idx(hi_idx), .any(hi_any));
   stk_pick #(.N(NREG), .IW(IW), .HIGH_FIRST(1'b0)) u_pick_lo (
      .vec(rem_q), .idx(lo_idx), .any(lo_any));

   logic            is_push, is_store, use_lr, use_pc, last;
   logic [IW-1:0]   cur_idx;
   logic [NREG-1:0] rem_nx;
   logic [DW-1:0]   ptr_nx;

   always_comb begin
      is_push  = (op_q == OP_PUSH) || (op_q == OP_PUSH_LR);
      is_store = is_push || (op_q == OP_BLK_ST);
      use_lr   = is_push & lr_pend_q;
      use_pc   = ~is_push & ~lo_any & pc_pend_q;
      cur_idx  = is_push ? hi_idx : lo_idx;
      rem_nx   = rem_q;
      if (!use_lr && !use_pc) rem_nx[cur_idx] = 1'b0;
      ptr_nx   = is_push ? ptr_q - DW'(STEP) : ptr_q + DW'(STEP);
      last     = (rem_nx == '0) && (use_lr || !lr_pend_q) && (use_pc || !pc_pend_q);
   end

   // request decode
   logic            accept, req_empty, req_block;
   stk_op_e         req_op_e;

   always_comb begin
      req_op_e  = stk_op_e'(req_op);
      accept    = req_valid && (st_q == ST_IDLE) && (req_op <= 3'd5);
      req_block = (req_op_e == OP_BLK_LD) || (req_op_e == OP_BLK_ST);
      req_empty = (req_list == '0) && (req_op_e != OP_PUSH_LR) && (req_op_e != OP_POP_PC);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         op_q      <= OP_PUSH;
         rem_q     <= '0;
         lr_pend_q <= 1'b0;
         pc_pend_q <= 1'b0;
         ptr_q     <= '0;
      end else begin
         unique case (st_q)
            ST_IDLE: if (accept) begin
               op_q      <= req_op_e;
               rem_q     <= req_list;
               lr_pend_q <= (req_op_e == OP_PUSH_LR);
               pc_pend_q <= (req_op_e == OP_POP_PC);
               ptr_q     <= (req_block && !req_empty) ? (req_base & ALIGN_MASK) : req_base;
               st_q      <= req_empty ? ST_FIN : ST_RUN;
            end
            ST_RUN: begin
               rem_q <= rem_nx;
               ptr_q <= ptr_nx;
               if (use_lr) lr_pend_q <= 1'b0;
               if (use_pc) pc_pend_q <= 1'b0;
               if (last)   st_q      <= ST_FIN;
            end
            ST_FIN:  st_q <= ST_IDLE;
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign mem_req   = (st_q == ST_RUN);
   assign mem_we    = mem_req & is_store;
   assign mem_addr  = is_push ? ptr_nx : ptr_q;
   assign mem_wdata = use_lr ? lr_val : lo_regs[cur_idx*DW +: DW];

   stk_rdpipe #(.DW(DW), .IW(IW)) u_rdpipe (
      .clk      (clk),
      .rst_n    (rst_n),
      .issue    (mem_req & ~is_store),
      .issue_idx(cur_idx),
      .issue_pc (use_pc),
      .rdata    (mem_rdata),
      .wb_en    (wb_en),
      .wb_idx   (wb_idx),
      .wb_data  (wb_data),
      .pc_load  (pc_load),
      .pc_val   (pc_val)
   );

   assign done   = (st_q == ST_FIN);
   assign sp_we  = done;
   assign sp_val = ptr_q;
   assign busy   = (st_q != ST_IDLE);
endmodule

// File: rtl/stk_seq_chk.sv
module stk_seq_chk #(
   parameter int DW   = 32,
   parameter int NREG = 8,
   parameter int IW   = $clog2(NREG)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          req_valid,
   input logic [2:0]    req_op,
   input logic          mem_req,
   input logic          mem_we,
   input logic [DW-1:0] mem_addr,
   input logic          wb_en,
   input logic          pc_load,
   input logic [DW-1:0] pc_val,
   input logic          done,
   input logic          busy
);
   localparam int STEP = DW / 8;

   logic [2:0] seen_op;
   always_ff @(posedge clk) begin
      if (!rst_n) seen_op <= 3'd0;
      else if (req_valid && !busy && req_op <= 3'd5) seen_op <= req_op;
   end

   logic down;
   assign down = (seen_op <= 3'd1);

   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R7
   AST_NO_ACCESS_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !mem_req); // R7
   AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && $past(mem_req)) |->
         (mem_addr == (down ? $past(mem_addr) - DW'(STEP) : $past(mem_addr) + DW'(STEP)))); // R2
   AST_BLOCK_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && seen_op >= 3'd4) |-> (mem_addr[1:0] == 2'b00)); // R6
   AST_WB_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en |-> $past(mem_req && !mem_we)); // R4
   AST_PC_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      pc_load |-> (done && !pc_val[0])); // R5
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mem_req && !done)); // R9
endmodule

bind stk_seq stk_seq_chk #(.DW(DW), .NREG(NREG), .IW(IW)) u_chk (.*);

// File: tb/stk_seq_bench.sv
module stk_seq_bench;
   localparam int CLK_PERIOD = 10;
   localparam int DW   = 32;
   localparam int NREG = 8;
   localparam int IW   = 3;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req_valid = 1'b0;
   logic [2:0]        req_op = '0;
   logic [NREG-1:0]   req_list = '0;
   logic [DW-1:0]     req_base = '0;
   logic [NREG*DW-1:0] lo_regs = '0;
   logic [DW-1:0]     lr_val = '0;
   logic              mem_req, mem_we;
   logic [DW-1:0]     mem_addr, mem_wdata;
   logic [DW-1:0]     mem_rdata = '0;
   logic              wb_en;
   logic [IW-1:0]     wb_idx;
   logic [DW-1:0]     wb_data;
   logic              sp_we, pc_load, done, busy;
   logic [DW-1:0]     sp_val, pc_val;

   int checks = 0;
   int failures = 0;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   stk_seq #(.DW(DW), .NREG(NREG)) u_stk_seq (.*);

   function automatic logic [DW-1:0] memf(input logic [DW-1:0] a);
      return (a * 32'h9E37_79B9) ^ 32'h1357_0001;
   endfunction

   always_ff @(posedge clk)
      if (mem_req && !mem_we) mem_rdata <= memf(mem_addr);

   task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // expected trace
   logic [DW-1:0] ea [0:9];
   logic          ew [0:9];
   logic [DW-1:0] ed [0:9];
   int            en;
   logic [IW-1:0] wi [0:7];
   logic [DW-1:0] wd [0:7];
   int            wn;
   logic [DW-1:0] exp_sp, exp_pc;
   bit            exp_pcv;

   task automatic build_exp(input logic [2:0] op, input logic [7:0] list, input logic [DW-1:0] base);
      logic [DW-1:0] p;
      bit empty;
      en = 0; wn = 0; exp_pcv = 0; exp_pc = '0;
      p = base;
      empty = (list == 0) && op != 3'd1 && op != 3'd3;
      if (op <= 3'd1) begin
         if (op == 3'd1) begin p -= 4; ea[en] = p; ew[en] = 1; ed[en] = lr_val; en++; end
         for (int i = 7; i >= 0; i--)
            if (list[i]) begin p -= 4; ea[en] = p; ew[en] = 1; ed[en] = lo_regs[i*DW +: DW]; en++; end
      end else begin
         if (op >= 3'd4 && !empty) p = base & ~32'd3;
         for (int i = 0; i < 8; i++)
            if (list[i]) begin
               ea[en] = p; ew[en] = (op == 3'd5); ed[en] = lo_regs[i*DW +: DW];
               if (op != 3'd5) begin wi[wn] = IW'(i); wd[wn] = memf(p); wn++; end
               en++; p += 4;
            end
         if (op == 3'd3) begin
            ea[en] = p; ew[en] = 0; ed[en] = '0; en++;
            exp_pcv = 1; exp_pc = memf(p) & ~32'd1; p += 4;
         end
      end
      exp_sp = p;
   endtask

   function automatic string rtag(input logic [2:0] op, input bit empty);
      if (empty) return "R8";
      case (op)
         3'd0: return "R2";
         3'd1: return "R3";
         3'd2: return "R4";
         3'd3: return "R5";
         default: return "R6";
      endcase
   endfunction

   task automatic run_txn(input logic [2:0] op, input logic [7:0] list, input logic [DW-1:0] base, input bit inject);
      int na, nw, cyc;
      bit got_done, ok, pc_seen, empty;
      string tag;
      empty = (list == 0) && op != 3'd1 && op != 3'd3;
      tag = rtag(op, empty);
      for (int i = 0; i < NREG; i++) lo_regs[i*DW +: DW] = $urandom;
      lr_val = $urandom;
      build_exp(op, list, base);
      @(negedge clk);
      req_valid = 1; req_op = op; req_list = list; req_base = base;
      @(negedge clk);
      req_valid = 0;
      na = 0; nw = 0; got_done = 0; pc_seen = 0; ok = 1;
      for (cyc = 0; cyc < 40; cyc++) begin
         if (inject && cyc == 1) begin
            req_valid = 1; req_op = 3'd2; req_list = 8'hFF; req_base = 32'h0000_8000;
         end else req_valid = 0;
         if (mem_req) begin
            if (na >= en || cyc != na) ok = 0;
            else begin
               chk(mem_addr == ea[na] && mem_we == ew[na], tag, mem_addr, ea[na]);
               if (ew[na]) chk(mem_wdata == ed[na], tag, mem_wdata, ed[na]);
            end
            na++;
         end
         if (wb_en) begin
            if (nw < wn) chk(wb_idx == wi[nw] && wb_data == wd[nw], "R4", wb_data, wd[nw]);
            else ok = 0;
            nw++;
         end
         if (pc_load) begin
            pc_seen = 1;
            chk(done && pc_val == exp_pc, "R5", pc_val, exp_pc);
         end
         if (done) begin
            got_done = 1;
            chk(sp_we && sp_val == exp_sp, tag, sp_val, exp_sp);
            break;
         end
         @(negedge clk);
      end
      req_valid = 0;
      chk(got_done && cyc == en, "R7", cyc, en);
      chk(ok && na == en, "R7", na, en);
      chk(nw == wn && pc_seen == exp_pcv, "R4", nw, wn);
      @(negedge clk);
      chk(!done && !busy && !mem_req, inject ? "R9" : "R7", {done, busy, mem_req}, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(!busy && !done && !mem_req && !wb_en && !sp_we && !pc_load, "R1",
          {busy, done, mem_req, wb_en, sp_we, pc_load}, 0);
      rst_n = 1;
      @(negedge clk);
      chk(!busy && !done && !mem_req, "R1", {busy, done, mem_req}, 0);
      void'($urandom(32'd20240611));

      run_txn(3'd0, 8'h81, 32'h0000_1000, 0);  // R2
      run_txn(3'd1, 8'h00, 32'h0000_1000, 0);  // R3 link only
      run_txn(3'd1, 8'hFF, 32'h0000_2000, 0);  // R3
      run_txn(3'd2, 8'h5A, 32'h0000_3000, 0);  // R4
      run_txn(3'd3, 8'h00, 32'h0000_3000, 0);  // R5 pc only
      run_txn(3'd3, 8'hFF, 32'h0000_3100, 0);  // R5
      run_txn(3'd4, 8'h0A, 32'h0000_2003, 0);  // R6 unaligned
      run_txn(3'd5, 8'hFF, 32'h0000_3002, 0);  // R6
      run_txn(3'd0, 8'h00, 32'h0000_1000, 0);  // R8
      run_txn(3'd4, 8'h00, 32'h0000_4003, 0);  // R8 base unchanged
      run_txn(3'd5, 8'hFF, 32'h0000_5000, 1);  // R9 request while busy
      run_txn(3'd1, 8'h3C, 32'h0000_6000, 1);  // R9

      // R9: op codes 6 and 7 ignored
      for (int k = 6; k < 8; k++) begin
         @(negedge clk);
         req_valid = 1; req_op = 3'(k); req_list = 8'hFF;
         @(negedge clk);
         req_valid = 0;
         chk(!busy && !mem_req && !done, "R9", {busy, mem_req, done}, 0);
         @(negedge clk);
         chk(!busy && !mem_req && !done, "R9", {busy, mem_req, done}, 0);
      end

      for (int t = 0; t < 300; t++) begin
         logic [2:0] op;
         logic [7:0] lst;
         op = 3'($urandom_range(0, 5));
         lst = ($urandom_range(0, 7) == 0) ? 8'h00 : 8'($urandom);
         run_txn(op, lst, $urandom, ($urandom_range(0, 9) == 0));
      end

      if (!finished) begin
         finished = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++;
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule